// File: doc/BRIEF.md
# Oversampled SPI Slave

This block is an SPI slave (mode 0, eight-bit bytes, most significant bit first) that lives wholly on one fast system clock. The select, serial clock and data-in pins are treated as plain data inputs. Each of them passes through its own flip-flop chain into the system domain. A one-stage history of the synchronized serial clock then yields its rising and falling edges. The receive shifter, the transmit shifter and the small control machine act only on those edge flags. The design therefore has no logic clocked by the serial clock. The system clock must run at least ten times faster than the serial clock, so every serial-clock half-period spans five or more system cycles.

On the system side, a received byte is presented on a parallel bus with a one-cycle valid strobe. The next byte to send is written into a one-entry holding register through a load/ready handshake. The holding register is emptied into the transmit shifter when the select line goes low and again at every byte boundary inside a frame. If the holding register is empty at that moment, a fixed fill byte is sent instead. While the slave is not selected, the data-out pin is released (its enable is low) and is held at logic 1.

Top module: `spi_ovs_slave`

## Requirements
- R1: After reset, and whenever the synchronized select is high, `sdo_oe` is 0, `sdo` is 1, `rx_valid` is 0, and `tx_ready` is 1 if no byte is being held.
- R2: `sdi` is captured at each detected rising edge of `sck`, most significant bit first. After the eighth rising edge, `rx_valid` is high for exactly one cycle and `rx_data` carries the byte.
- R3: `rx_valid` is high in the third system cycle after the cycle in which `sck` rises for the eighth bit. It is still low after the first and second cycles.
- R4: Several bytes can be exchanged in one select period without deasserting `ss_n`. Every group of eight rising edges yields one `rx_valid`.
- R5: Within three system cycles of `ss_n` falling, `sdo_oe` is 1 and `sdo` shows bit 7 of the transmit byte. Each following bit appears after a falling edge of `sck`, and it is settled before the next rising edge. `sdo_oe` is only high while the slave is selected.
- R6: A `tx_load` pulse while `tx_ready` is 1 stores `tx_data`, and `tx_ready` reads 0 from the next cycle. `tx_ready` returns to 1 once the stored byte has moved into the transmit shifter, either at select fall or at the falling edge that follows a byte boundary.
- R7: A `tx_load` pulse while `tx_ready` is 0 is ignored. The byte already held is the one that is transmitted.
- R8: A byte slot that finds the holding register empty transmits the fill value 0x00.
- R9: Raising `ss_n` before eight rising edges discards the partial byte without an `rx_valid` pulse. The next frame starts again at bit 7.
- R10: Activity on `sck` and `sdi` while `ss_n` is high produces no `rx_valid` and leaves `sdo` at its idle level.
- R11: A first rising edge of `sck` that arrives in the same system cycle as the falling edge of `ss_n` is still captured as bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_n | input | 1 | Slave select from the master, active low, asynchronous |
| sck | input | 1 | Serial clock from the master, sampled as data |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master, 1 when idle |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| tx_data | input | DATA_W | Byte to queue for transmission |
| tx_load | input | 1 | Write strobe for `tx_data` |
| tx_ready | output | 1 | Holding register is empty and can accept a byte |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |

## Verification
A bit counter that slips shows up on the next received byte. That byte arrives rotated, or its `rx_valid` pulse is early or missing, within one byte of the fault. A wrong holding-register flag shows on `sdo` at the next byte slot: a queued byte is replaced by the fill value, or a stale byte is repeated. It also leaves `tx_ready` at the wrong level in the cycle after a load. An edge detector or a synchronizer tap that is off by a stage moves the `rx_valid` timing away from the three-cycle mark. It also corrupts the first bit when select and clock change together.

// File: rtl/spi_ovs_pkg.sv
package spi_ovs_pkg;

    // Frame controller state
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } ctl_state_t;

    // Raw pin bundle as seen by the synchronizer
    typedef struct packed {
        logic ss_n;
        logic sck;
        logic sdi;
    } pin_bundle_t;

    // Detected serial-clock transitions
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    localparam int unsigned PIN_COUNT = $bits(pin_bundle_t);

    // Reset image of the pins: deselected, clock low, data low
    localparam pin_bundle_t PIN_IDLE = '{ss_n: 1'b1, sck: 1'b0, sdi: 1'b0};

    // Shift one bit into the low end of a byte-wide register
    function automatic logic [7:0] shift_in8(input logic [7:0] cur, input logic b);
        return {cur[6:0], b};
    endfunction

endpackage

// File: rtl/spi_ovs_sync.sv
module spi_ovs_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // One independent flop chain per input bit
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_ovs_edge.sv
module spi_ovs_edge
    import spi_ovs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_s,
    output sck_edge_t edge_o
);

    logic sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_s;
        end
    end

    // Adjacent-sample comparison of the synchronized clock
    always_comb begin
        edge_o.rise = sck_s & ~sck_prev;
        edge_o.fall = ~sck_s & sck_prev;
    end

endmodule

// File: rtl/spi_ovs_core.sv
module spi_ovs_core
    import spi_ovs_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] FILL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ss_act,
    input  logic              sdi_s,
    input  sck_edge_t         edge_i,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    ctl_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] hold;
    logic              hold_full;
    logic [DATA_W-1:0] next_tx;
    logic [DATA_W-1:0] rx_next;
    logic              take_hold;

    // Byte for the next slot: queued data, else fill
    assign next_tx = hold_full ? hold : FILL;
    assign rx_next = {rx_sh[DATA_W-2:0], sdi_s};

    // Holding register is drained at select fall and at byte boundaries
    assign take_hold = ss_act &&
                       ((state == ST_IDLE) ||
                        (edge_i.fall && (bit_cnt == '0)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            sdo_oe    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;

            if (take_hold) begin
                tx_sh     <= next_tx;
                hold_full <= 1'b0;
            end

            if (tx_load && !hold_full) begin
                hold      <= tx_data;
                hold_full <= 1'b1;
            end

            if (!ss_act) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sdo_oe  <= 1'b0;
            end else begin
                if (state == ST_IDLE) begin
                    state  <= ST_ACTIVE;
                    sdo_oe <= 1'b1;
                end else if (edge_i.fall && (bit_cnt != '0)) begin
                    tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                end

                if (edge_i.rise) begin
                    rx_sh <= rx_next;
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt  <= '0;
                        rx_data  <= rx_next;
                        rx_valid <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign tx_ready = ~hold_full;
    assign sdo      = sdo_oe ? tx_sh[DATA_W-1] : 1'b1;

endmodule

// File: rtl/spi_ovs_slave.sv
module spi_ovs_slave
    import spi_ovs_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] FILL  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ss_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    pin_bundle_t pins_raw;
    pin_bundle_t pins_s;
    sck_edge_t   sck_edge;
    logic        ss_act;
    logic        sck_rise;
    logic        sck_fall;

    assign pins_raw = '{ss_n: ss_n, sck: sck, sdi: sdi};

    spi_ovs_sync #(
        .W       (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign ss_act = ~pins_s.ss_n;

    spi_ovs_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sck_s  (pins_s.sck),
        .edge_o (sck_edge)
    );

    assign sck_rise = sck_edge.rise;
    assign sck_fall = sck_edge.fall;

    spi_ovs_core #(
        .DATA_W (DATA_W),
        .FILL   (FILL)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .ss_act   (ss_act),
        .sdi_s    (pins_s.sdi),
        .edge_i   (sck_edge),
        .tx_data  (tx_data),
        .tx_load  (tx_load),
        .tx_ready (tx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

endmodule

// File: rtl/spi_ovs_checker.sv
module spi_ovs_checker (
    input logic clk,
    input logic rst,
    input logic ss_act,
    input logic sck_rise,
    input logic sck_fall,
    input logic rx_valid,
    input logic tx_load,
    input logic tx_ready,
    input logic sdo,
    input logic sdo_oe
);

    assert_idle_level_R1: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> sdo);

    assert_rx_single_R2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_edge_excl_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sck_rise, sck_fall}));

    assert_drive_selected_R5: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> $past(ss_act));

    assert_load_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_load && tx_ready) |=> !tx_ready);

    assert_rx_selected_R9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(ss_act));

endmodule

bind spi_ovs_slave spi_ovs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ss_act   (ss_act),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .rx_valid (rx_valid),
    .tx_load  (tx_load),
    .tx_ready (tx_ready),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
);

// File: tb/tb_spi_ovs_slave.sv
module tb_spi_ovs_slave;

    localparam int HALF = 6;
    localparam logic [7:0] FILL = 8'h00;

    logic       clk = 1'b0;
    logic       rst;
    logic       ss_n, sck, sdi, tx_load;
    logic [7:0] tx_data;
    logic       sdo, sdo_oe, tx_ready, rx_valid;
    logic [7:0] rx_data;

    int   n_cmp = 0;
    int   n_bad = 0;
    logic [7:0] rxq[$];
    logic rxv_prev = 1'b0;

    always #10 clk = ~clk;

    spi_ovs_slave dut (
        .clk(clk), .rst(rst), .ss_n(ss_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .tx_data(tx_data), .tx_load(tx_load),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Receive monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) rxq.push_back(rx_data);
            if (rx_valid && rxv_prev) chk(1'b0, "R2 strobe width", 2, 1);
        end
        rxv_prev <= rx_valid;
    end

    function automatic logic [7:0] exp_miso(input int k, input int nload, input logic [7:0] l0, input logic [7:0] l1);
        if (k < nload) return (k == 0) ? l0 : l1;
        return FILL;
    endfunction

    task automatic load_tx(input logic [7:0] b);
        int guard = 0;
        @(negedge clk);
        while (!tx_ready && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        chk(tx_ready == 1'b1, "R6 ready before load", tx_ready, 1);
        tx_data = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        chk(tx_ready == 1'b0, "R6 ready drops after load", tx_ready, 0);
    endtask

    task automatic xfer_bit(input logic d, input bit do_chk, input logic e, input string req);
        sdi = d;
        repeat (HALF) @(negedge clk);
        if (do_chk) chk(sdo === e && sdo_oe === 1'b1, req, {sdo_oe, sdo}, {1'b1, e});
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] mo, input logic [7:0] me);
        for (int i = 7; i >= 0; i--) xfer_bit(mo[i], 1'b1, me[i], "R5 sdo bit");
    endtask

    task automatic end_frame();
        repeat (HALF) @(negedge clk);
        ss_n = 1'b1;
        repeat (HALF) @(negedge clk);
        chk(sdo === 1'b1 && sdo_oe === 1'b0, "R1 idle after frame", {sdo_oe, sdo}, 2'b01);
    endtask

    task automatic run_frame(input int n, input logic [7:0] mo[4], input int nload,
                             input logic [7:0] l0, input logic [7:0] l1);
        rxq.delete();
        if (nload > 0) load_tx(l0);
        ss_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(sdo_oe === 1'b1 && sdo === exp_miso(0, nload, l0, l1)[7], "R5 first bit on select",
            {sdo_oe, sdo}, {1'b1, exp_miso(0, nload, l0, l1)[7]});
        if (nload > 0) chk(tx_ready == 1'b1, "R6 ready after take", tx_ready, 1);
        if (nload > 1) load_tx(l1);
        for (int k = 0; k < n; k++) xfer_byte(mo[k], exp_miso(k, nload, l0, l1));
        end_frame();
        chk(rxq.size() == n, "R4 byte count", rxq.size(), n);
        for (int k = 0; k < n; k++)
            if (k < rxq.size()) chk(rxq[k] == mo[k], "R2 rx byte", rxq[k], mo[k]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] mo[4];
        logic [7:0] b;
        void'($urandom(32'd1357));
        rst = 1'b1; ss_n = 1'b1; sck = 1'b0; sdi = 1'b0; tx_load = 1'b0; tx_data = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sdo === 1'b1, "R1 sdo idle", sdo, 1);
        chk(sdo_oe === 1'b0, "R1 oe idle", sdo_oe, 0);
        chk(rx_valid === 1'b0, "R1 no strobe", rx_valid, 0);
        chk(tx_ready === 1'b1, "R1 ready", tx_ready, 1);

        // Directed single byte with queued data
        mo = '{8'hA5, 8'h00, 8'h00, 8'h00};
        run_frame(1, mo, 1, 8'h3C, 8'h00);

        // Two bytes, both queued (R4, R6)
        mo = '{8'h81, 8'h7E, 8'h00, 8'h00};
        run_frame(2, mo, 2, 8'hC3, 8'h5A);

        // R8: three slots, two queued, last slot gets fill
        mo = '{8'h12, 8'h34, 8'h56, 8'h00};
        run_frame(3, mo, 2, 8'hF0, 8'h0F);

        // R7: second load while full is ignored
        load_tx(8'hE7);
        @(negedge clk);
        tx_data = 8'h18; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        chk(tx_ready == 1'b0, "R7 ready stays low", tx_ready, 0);
        rxq.delete();
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        xfer_byte(8'h99, 8'hE7);
        xfer_byte(8'h66, FILL);
        end_frame();
        chk(rxq.size() == 2, "R7 byte count", rxq.size(), 2);

        // R9: partial byte discarded, then clean frame
        rxq.delete();
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 5; i++) xfer_bit(1'b1, 1'b0, 1'b0, "");
        end_frame();
        chk(rxq.size() == 0, "R9 no strobe on partial", rxq.size(), 0);
        mo = '{8'h4B, 8'h00, 8'h00, 8'h00};
        run_frame(1, mo, 0, 8'h00, 8'h00);

        // R10: activity while deselected
        rxq.delete();
        for (int i = 0; i < 10; i++) begin
            xfer_bit(i[0], 1'b0, 1'b0, "");
            chk(sdo === 1'b1 && sdo_oe === 1'b0, "R10 sdo idle while deselected", {sdo_oe, sdo}, 2'b01);
        end
        chk(rxq.size() == 0, "R10 no strobe while deselected", rxq.size(), 0);

        // R3: strobe latency from the eighth rising edge
        rxq.delete();
        b = 8'hD2;
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 7; i >= 1; i--) xfer_bit(b[i], 1'b0, 1'b0, "");
        sdi = b[0];
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
        chk(rx_valid === 1'b0, "R3 strobe not before third cycle", rx_valid, 0);
        @(negedge clk);
        chk(rx_valid === 1'b1, "R3 strobe in third cycle", rx_valid, 1);
        chk(rx_data == b, "R3 byte with strobe", rx_data, b);
        repeat (HALF - 3) @(negedge clk);
        sck = 1'b0;
        end_frame();

        // R11: select fall in the same cycle as the first rising edge
        rxq.delete();
        b = 8'hB4;
        sdi = b[7];
        repeat (HALF) @(negedge clk);
        ss_n = 1'b0; sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
        for (int i = 6; i >= 0; i--) xfer_bit(b[i], 1'b0, 1'b0, "");
        end_frame();
        chk(rxq.size() == 1, "R11 byte count", rxq.size(), 1);
        if (rxq.size() > 0) chk(rxq[0] == b, "R11 first bit kept", rxq[0], b);

        // Random frames
        for (int f = 0; f < 24; f++) begin
            int n, nl, mx;
            n  = 1 + int'($urandom % 3);
            mx = (n < 2) ? n : 2;
            nl = int'($urandom % (mx + 1));
            for (int k = 0; k < 4; k++) mo[k] = 8'($urandom);
            run_frame(n, mo, nl, 8'($urandom), 8'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule